// File: doc/BRIEF.md
# Regulator Command Sequencer

This block keeps a small file of command words and plays a chain of them out, one byte at a time, to an external power-management regulator. It does not drive the serial wires itself. It hands each byte to a byte-level transmitter through a request/ready handshake, and that transmitter reports with a done pulse when a transfer has closed. A sequence starts either from a software start pulse or from a frequency-change request, the second only when coupling is enabled. Each sequence begins at a programmable read pointer and walks upward through the file. It wraps from the top entry back to entry 0 and stops after the first command marked as final. The pointer is kept between sequences, so it is left on the final command that was sent.

Each command word carries one data byte and four flags. The final flag ends the chain. The burst flag keeps the transfer open, and the next byte follows without waiting for the transmitter to finish. The wait flag inserts a programmable number of 13 MHz oscillator ticks before the byte. The static flag holds the byte back until the core clocks are reported off. A run-away chain with no final flag is cut off after one full pass over the file, and an error is raised.

The controller is one state machine with the states IDLE, CHECK, DELAY, GATE, SEND, WAIT and NEXT. IDLE goes to CHECK on an accepted start. CHECK goes to SEND for a command that continues a burst, to DELAY for a command with the wait flag, and to GATE otherwise. DELAY goes to GATE once the tick count has run out. GATE goes to SEND when the command is dynamic or the clocks are off. SEND goes to NEXT when a burst byte is accepted, and to WAIT when any other byte is accepted. WAIT goes to NEXT on transmitter done. NEXT goes to IDLE on a final command or at the pass limit, and to CHECK otherwise.

Top module: `reg_cmd_seq`

## Requirements
- R1: After reset, tx_req, busy, done and err are low and rd_ptr is 0.
- R2: A command word is {static[11], wait[10], burst[9], final[8], data[7:0]}. A software start sends the data bytes of consecutive entries, beginning at the entry that rd_ptr selects.
- R3: After each non-final command, rd_ptr advances by one. After a final command the sequence ends, rd_ptr stays on that command, and done pulses high for one cycle.
- R4: A non-final command in the top entry (31) is followed by entry 0.
- R5: After a byte with the burst flag set is accepted, the next command is requested within 3 cycles, without waiting for tx_done and ignoring that command's wait and static flags. tx_hold equals the burst flag of the byte offered.
- R6: A command with the wait flag set, that does not continue a burst, is not requested until the number of osc_tick pulses held in the delay setting has been seen.
- R7: A static command that does not continue a burst is not requested while clk_off is low.
- R8: fc_start starts a sequence only while couple_en is high. Otherwise it has no effect.
- R9: While busy, start pulses and writes to the command file and to the pointer are ignored.
- R10: If 32 commands are sent without a final flag, the sequence stops, err is set without a done pulse, and rd_ptr stays on the 32nd command. err clears on the next accepted start.
- R11: After a byte with the burst flag clear is accepted, the next command is not requested before tx_done has pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command file write strobe |
| cmd_addr | input | 5 | Command entry to write |
| cmd_wdata | input | 12 | Command word to write |
| ptr_we | input | 1 | Read pointer write strobe |
| ptr_wdata | input | 5 | New read pointer |
| dly_we | input | 1 | Delay setting write strobe |
| dly_wdata | input | 8 | Number of oscillator ticks to wait |
| sw_start | input | 1 | Software start pulse |
| fc_start | input | 1 | Frequency-change start pulse |
| couple_en | input | 1 | Lets fc_start begin a sequence |
| clk_off | input | 1 | Core clocks are stopped |
| osc_tick | input | 1 | One pulse per 13 MHz oscillator cycle |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_done | input | 1 | Transmitter finished a transfer |
| tx_req | output | 1 | Byte offered to transmitter |
| tx_byte | output | 8 | Offered byte |
| tx_hold | output | 1 | Keep the transfer open after this byte |
| rd_ptr | output | 5 | Current read pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at normal completion |
| err | output | 1 | Sequence ended without a final flag |

## Verification
A wrong pointer or step shows up at the very next accepted byte, because each byte's value identifies the entry it came from. A broken flag decision shows up within a few cycles. It appears as a byte offered too early (before the tick count has run out, before clocks-off, or before tx_done), or as a burst that stalls longer than three cycles. A bad pass counter or bad final handling shows up when the sequence ends, through the number of bytes sent, the final rd_ptr, and which of done and err is raised.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef struct packed {
        logic       stat;
        logic       wait_f;
        logic       burst;
        logic       fin;
        logic [7:0] data;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_DELAY, S_GATE, S_SEND, S_WAIT, S_NEXT
    } state_t;
endpackage

// File: rtl/rcs_cmd_file.sv
module rcs_cmd_file
    import rcs_pkg::*;
#(
    parameter int NUM_CMDS = 32,
    localparam int PTR_W   = $clog2(NUM_CMDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  cmd_t             wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output cmd_t             rd_cmd
);
    cmd_t entries [NUM_CMDS];

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                entries[g] <= '0;
            else if (wr_en && wr_addr == PTR_W'(g))
                entries[g] <= wr_data;
        end
    end

    assign rd_cmd = entries[rd_addr];
endmodule

// File: rtl/rcs_dly_timer.sv
module rcs_dly_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> ($past(tick) || $past(load))); // R6
endmodule

// File: rtl/rcs_seq_fsm.sv
module rcs_seq_fsm
    import rcs_pkg::*;
#(
    parameter int NUM_CMDS = 32,
    localparam int PTR_W   = $clog2(NUM_CMDS),
    localparam int CNT_W   = $clog2(NUM_CMDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  cmd_t             cur,
    input  logic             clk_off,
    input  logic             dly_expired,
    input  logic             tx_ready,
    input  logic             tx_done,
    output logic             dly_load,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             tx_req,
    output logic [7:0]       tx_byte,
    output logic             tx_hold,
    output logic             busy,
    output logic             done,
    output logic             err
);
    state_t state, state_nx;
    logic [CNT_W-1:0] cmd_cnt;
    logic             burst_q;
    logic             at_limit;

    assign at_limit = (cmd_cnt == CNT_W'(NUM_CMDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_CHECK;
            S_CHECK: begin
                if (burst_q)         state_nx = S_SEND;
                else if (cur.wait_f) state_nx = S_DELAY;
                else                 state_nx = S_GATE;
            end
            S_DELAY: if (dly_expired) state_nx = S_GATE;
            S_GATE:  if (!cur.stat || clk_off) state_nx = S_SEND;
            S_SEND:  if (tx_ready) state_nx = cur.burst ? S_NEXT : S_WAIT;
            S_WAIT:  if (tx_done) state_nx = S_NEXT;
            S_NEXT:  state_nx = (cur.fin || at_limit) ? S_IDLE : S_CHECK;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        tx_req   = (state == S_SEND);
        tx_byte  = cur.data;
        tx_hold  = cur.burst;
        busy     = (state != S_IDLE);
        dly_load = (state == S_CHECK) && !burst_q && cur.wait_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            cmd_cnt <= '0;
            burst_q <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= (state == S_NEXT) && cur.fin;
            if (state == S_IDLE) begin
                if (start) begin
                    cmd_cnt <= '0;
                    burst_q <= 1'b0;
                    err     <= 1'b0;
                end else if (ptr_we) begin
                    rd_ptr <= ptr_wdata;
                end
            end else if (state == S_NEXT && !cur.fin) begin
                if (at_limit) begin
                    err <= 1'b1;
                end else begin
                    rd_ptr  <= (rd_ptr == PTR_W'(NUM_CMDS - 1)) ? '0 : rd_ptr + 1'b1;
                    cmd_cnt <= cmd_cnt + 1'b1;
                    burst_q <= cur.burst;
                end
            end
        end
    end

    AST_STATIC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_req) && cur.stat && !burst_q) |-> $past(clk_off)); // R7
    AST_PTR_KEPT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $stable(rd_ptr)); // R3
    AST_PTR_MOVES_IN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr) && $past(busy)) |-> $past(state == S_NEXT)); // R9
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, tx_req, $rose(err)})); // R10
    AST_WAIT_FOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !tx_done) |=> !tx_req); // R11
    AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cnt <= CNT_W'(NUM_CMDS - 1)); // R10
endmodule

// File: rtl/reg_cmd_seq.sv
module reg_cmd_seq
    import rcs_pkg::*;
#(
    parameter int NUM_CMDS = 32,
    parameter int DLY_W    = 8,
    localparam int PTR_W   = $clog2(NUM_CMDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [PTR_W-1:0] cmd_addr,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             dly_we,
    input  logic [DLY_W-1:0] dly_wdata,
    input  logic             sw_start,
    input  logic             fc_start,
    input  logic             couple_en,
    input  logic             clk_off,
    input  logic             osc_tick,
    input  logic             tx_ready,
    input  logic             tx_done,
    output logic             tx_req,
    output logic [7:0]       tx_byte,
    output logic             tx_hold,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             busy,
    output logic             done,
    output logic             err
);
    cmd_t             cur;
    logic             start;
    logic             dly_load;
    logic             dly_expired;
    logic [DLY_W-1:0] dly_cfg;

    assign start = sw_start || (fc_start && couple_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                dly_cfg <= '0;
        else if (dly_we && !busy)  dly_cfg <= dly_wdata;
    end

    rcs_cmd_file #(.NUM_CMDS(NUM_CMDS)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_we && !busy),
        .wr_addr (cmd_addr),
        .wr_data (cmd_t'(cmd_wdata)),
        .rd_addr (rd_ptr),
        .rd_cmd  (cur)
    );

    rcs_dly_timer #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dly_load),
        .load_val (dly_cfg),
        .tick     (osc_tick),
        .expired  (dly_expired)
    );

    rcs_seq_fsm #(.NUM_CMDS(NUM_CMDS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ptr_we      (ptr_we),
        .ptr_wdata   (ptr_wdata),
        .cur         (cur),
        .clk_off     (clk_off),
        .dly_expired (dly_expired),
        .tx_ready    (tx_ready),
        .tx_done     (tx_done),
        .dly_load    (dly_load),
        .rd_ptr      (rd_ptr),
        .tx_req      (tx_req),
        .tx_byte     (tx_byte),
        .tx_hold     (tx_hold),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy || done || err); // R9
endmodule

// File: tb/reg_cmd_seq_tb.sv
module reg_cmd_seq_tb;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 0, ptr_we = 0, dly_we = 0;
    logic [4:0]  cmd_addr = 0, ptr_wdata = 0;
    logic [11:0] cmd_wdata = 0;
    logic [7:0]  dly_wdata = 0;
    logic        sw_start = 0, fc_start = 0, couple_en = 0;
    logic        clk_off = 1, osc_tick = 0, tx_ready = 1, tx_done = 0;
    logic        tx_req, tx_hold, busy, done, err;
    logic [7:0]  tx_byte;
    logic [4:0]  rd_ptr;

    int nchk = 0, nfail = 0, cyc = 0, dcnt = 0, nlog = 0;
    logic [7:0] lb [64];
    logic       lh [64];
    int         lc [64];
    bit         done_seen = 0;

    always #4 clk = ~clk;

    reg_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .dly_we(dly_we), .dly_wdata(dly_wdata), .sw_start(sw_start),
        .fc_start(fc_start), .couple_en(couple_en), .clk_off(clk_off),
        .osc_tick(osc_tick), .tx_ready(tx_ready), .tx_done(tx_done),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_hold(tx_hold), .rd_ptr(rd_ptr),
        .busy(busy), .done(done), .err(err)
    );

    // byte transmitter model: done only closes a transfer (hold low)
    always @(negedge clk) begin
        cyc++;
        tx_done = 1'b0;
        if (dcnt > 0) begin
            dcnt--;
            if (dcnt == 0) tx_done = 1'b1;
        end
        if (tx_req && tx_ready && nlog < 64) begin
            lb[nlog] = tx_byte; lh[nlog] = tx_hold; lc[nlog] = cyc;
            nlog++;
            if (!tx_hold) dcnt = LAT;
        end
        if (done) done_seen = 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tk;
        @(posedge clk); #2;
    endtask

    task automatic wr_cmd(input int idx, input bit st, input bit wt, input bit bu, input bit fi, input logic [7:0] d);
        tk(); cmd_we = 1; cmd_addr = 5'(idx); cmd_wdata = {st, wt, bu, fi, d};
        tk(); cmd_we = 0;
    endtask

    task automatic set_ptr(input int p);
        tk(); ptr_we = 1; ptr_wdata = 5'(p);
        tk(); ptr_we = 0;
    endtask

    task automatic go;
        nlog = 0; done_seen = 0;
        tk(); sw_start = 1;
        tk(); sw_start = 0;
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 3000 && busy; i++) tk();
        repeat (3) tk();
    endtask

    // start pointer, byte count, final pointer
    localparam logic [15:0] VEC [6] = '{
        {5'd0,  6'd3, 5'd2},   // R2 R3
        {5'd5,  6'd1, 5'd5},   // R3
        {5'd30, 6'd5, 5'd2},   // R4 wrap
        {5'd1,  6'd2, 5'd2},
        {5'd8,  6'd3, 5'd10},  // burst chain
        {5'd12, 6'd1, 5'd12}   // wait flag, zero count
    };

    initial begin
        repeat (3) tk();
        check(!tx_req && !busy && !done && !err && rd_ptr == 0, "R1 reset", int'(rd_ptr), 0);
        rst_n = 1;
        tk();
        for (int i = 0; i < 32; i++) wr_cmd(i, 0, 0, 0, 1, 8'(8'h40 + i));
        wr_cmd(0, 0, 0, 0, 0, 8'h40);  wr_cmd(1, 0, 0, 0, 0, 8'h41);
        wr_cmd(30, 0, 0, 0, 0, 8'h5E); wr_cmd(31, 0, 0, 0, 0, 8'h5F);
        wr_cmd(8, 0, 0, 1, 0, 8'h48);  wr_cmd(9, 1, 0, 1, 0, 8'h49);
        wr_cmd(12, 0, 1, 0, 1, 8'h4C); wr_cmd(13, 1, 0, 0, 1, 8'h4D);

        for (int v = 0; v < 6; v++) begin
            int sp, nb, fp;
            bit ok;
            sp = int'(VEC[v][15:11]); nb = int'(VEC[v][10:5]); fp = int'(VEC[v][4:0]);
            set_ptr(sp); go(); wait_idle();
            check(nlog == nb, "R2 byte count", nlog, nb);
            ok = 1;
            for (int k = 0; k < nlog; k++)
                if (lb[k] != 8'(8'h40 + ((sp + k) % 32))) ok = 0;
            check(ok, "R2 byte order", int'(lb[0]), 8'h40 + sp);
            check(rd_ptr == 5'(fp), "R3 R4 final pointer", int'(rd_ptr), fp);
            check(done_seen && !err, "R3 done pulse", int'(done_seen), 1);
            if (v == 0) check(lc[1] - lc[0] > LAT, "R11 waits for tx_done", lc[1] - lc[0], LAT + 1);
        end

        // R5: burst with clocks on, entry 9 is static yet follows at once
        clk_off = 0;
        set_ptr(8); go(); wait_idle();
        check(nlog == 3, "R5 burst count", nlog, 3);
        check(lc[1] - lc[0] <= 3, "R5 no wait in burst", lc[1] - lc[0], 3);
        check(lh[0] && lh[1] && !lh[2], "R5 hold flags", int'({lh[0], lh[1], lh[2]}), 6);

        // R7 / R9: static command blocked; start, pointer and file writes ignored
        set_ptr(13); go();
        repeat (20) tk();
        check(nlog == 0 && busy, "R7 static held", nlog, 0);
        tk(); sw_start = 1; ptr_we = 1; ptr_wdata = 5'd0; tk(); sw_start = 0; ptr_we = 0;
        wr_cmd(13, 0, 0, 0, 1, 8'hEE);
        clk_off = 1;
        wait_idle(); repeat (10) tk();
        check(nlog == 1 && !busy, "R9 start ignored", nlog, 1);
        check(rd_ptr == 13, "R9 ptr write ignored", int'(rd_ptr), 13);
        go(); wait_idle();
        check(nlog == 1 && lb[0] == 8'h4D, "R9 file write ignored", int'(lb[0]), 8'h4D);

        // R6: wait of 5 oscillator ticks
        tk(); dly_we = 1; dly_wdata = 8'd5; tk(); dly_we = 0;
        set_ptr(12); go();
        repeat (30) tk();
        check(nlog == 0, "R6 no tick no send", nlog, 0);
        for (int t = 0; t < 4; t++) begin
            tk(); osc_tick = 1; tk(); osc_tick = 0; tk();
        end
        repeat (10) tk();
        check(nlog == 0, "R6 four ticks not enough", nlog, 0);
        tk(); osc_tick = 1; tk(); osc_tick = 0;
        repeat (8) tk();
        check(nlog == 1 && lb[0] == 8'h4C, "R6 sent after fifth tick", nlog, 1);
        wait_idle();

        // R8: coupled start
        set_ptr(5); nlog = 0;
        tk(); fc_start = 1; tk(); fc_start = 0;
        repeat (10) tk();
        check(!busy && nlog == 0, "R8 uncoupled ignored", nlog, 0);
        couple_en = 1;
        tk(); fc_start = 1; tk(); fc_start = 0;
        wait_idle();
        check(nlog == 1 && lb[0] == 8'h45, "R8 coupled start", int'(lb[0]), 8'h45);

        // R10: no final flag anywhere
        for (int i = 0; i < 32; i++) wr_cmd(i, 0, 0, 0, 0, 8'(8'h40 + i));
        set_ptr(4); go(); wait_idle();
        check(nlog == 32, "R10 pass limit count", nlog, 32);
        check(err && !done_seen, "R10 error raised", int'(err), 1);
        check(rd_ptr == 3, "R10 pointer at last sent", int'(rd_ptr), 3);
        go(); repeat (2) tk();
        check(!err && busy, "R10 err cleared on start", int'(err), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule